// File: doc/BRIEF.md
# Programmable periodic wake-up interrupt timer

This block raises a periodic interrupt flag from a 16-bit rate value. It can count one of two clocks. The first is a slow autonomous clock that keeps running when the bus clock is quiet, for wake-up use. The second is the bus clock itself. One period lasts twice the rate value plus one cycles of the chosen clock. At the end of every period the block sets a sticky flag. The interrupt output is that flag gated by an interrupt-enable bit. Software clears the flag by writing 1 to it.

Software reaches the block through four byte-wide registers. Address 0 is the control register: bit 0 is the run enable, bit 1 is the clock source (1 selects the bus clock, 0 the autonomous clock) and bit 2 is the interrupt enable. Address 1 holds the flag in bit 0. Address 2 holds rate bits 15..8 and address 3 holds rate bits 7..0. The rate bytes and the source bit are frozen while the timer runs, so a period already in progress always matches what software set.

In autonomous-clock mode the run enable reaches the counter through a two-stage synchronizer clocked by the autonomous clock. This is the clock-gate release, and it delays the first period by two to three autonomous cycles. Each timeout in that domain flips a toggle. The toggle is synchronized back to the bus clock and turned into a single flag-set pulse.

Top module: `wake_timer`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is 0.
- R2: While the run enable is 0, bytes written to address 2 and address 3 read back unchanged. Address 2 holds rate bits 15..8 and address 3 holds rate bits 7..0.
- R3: While the run enable (control bit 0) is 1, writes to address 2 or address 3 leave both rate bytes unchanged.
- R4: With the bus clock selected (control bit 1 = 1), the flag is first set exactly 2*(rate+1) bus cycles after the clock edge that writes the run enable to 1. Every later set follows the previous one by 2*(rate+1) bus cycles.
- R5: With the autonomous clock selected (control bit 1 = 0), successive flag sets are exactly 2*(rate+1) autonomous-clock periods apart.
- R6: In autonomous mode, the first flag set comes no sooner than (P+1) and no later than (P+3) autonomous periods plus 20 ns after the enabling edge, where P = 2*(rate+1).
- R7: The flag (address 1, bit 0) stays set until software writes 1 to bit 0 of address 1. Writing 0 to that bit leaves the flag unchanged.
- R8: `irq` equals the flag ANDed with the interrupt enable (control bit 2). With the enable at 0, a set flag does not raise `irq`.
- R9: While the run enable is 1, a control write leaves the clock-source bit unchanged.
- R10: While the run enable is 0, the counter holds at zero and the flag is never set. Re-enabling starts a fresh, full period.
- R11: Each autonomous-domain timeout yields exactly one single-cycle flag-set pulse in the bus domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, used in both clock domains |
| aclk | input | 1 | Autonomous slow clock |
| addr | input | 2 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, sampled on the bus clock |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request: the flag ANDed with the interrupt enable |

## Verification
The bench sweeps the rate from 0 to 15, plus one value with a nonzero high byte, in bus-clock mode. It checks the cycle of every flag set against 2*(rate+1). An off-by-one end count, a lost reload cycle or a byte-order mix-up therefore shows up as a wrong interval. Autonomous mode is swept over small rates. The bench checks the exact spacing, which a double flag set from a badly built synchronizer would break. It also checks the window for the first period, which a missing or doubled gate-release stage would move. Separate cases cover writes to the rate and the clock source while the timer runs, write-0 and write-1 to the flag, masking by the interrupt enable, and the behaviour while disabled followed by re-enabling. A design that failed any of these would read back changed values, keep or lose the flag, raise `irq` while masked, or start a partial period.

// File: rtl/wt_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the wake-up timer.
// Holds the register addresses, the control-bit positions and the rate width.
package wt_pkg;
    localparam int RATE_W = 16;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_RHI  = 2'd2;
    localparam logic [ADDR_W-1:0] A_RLO  = 2'd3;

    localparam int B_RUN = 0;
    localparam int B_SRC = 1;
    localparam int B_IEN = 2;

    localparam int B_FLAG = 0;
endpackage

// File: rtl/wt_period_counter.sv
`timescale 1ns/1ps
// Module: wt_period_counter
// Counts 2*(rate+1) edges of its clock while run is high. On the last count
// it raises tick for one cycle and wraps back to zero in the same edge, so no
// cycle is lost. While run is low the count is held at zero.
// Assumes rate stays stable while run is high (the register block locks it).
module wt_period_counter #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = RATE_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Terminal count is 2*rate+1, which gives 2*(rate+1) states per period.
    assign last = {rate, 1'b1};
    assign tick = run && (cnt == last);

    // Count-up process: clear on reset or idle, wrap on terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R4: a running count never passes the terminal value
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= last));

    // R10: an idle counter is at zero on the next cycle
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/wt_sync.sv
`timescale 1ns/1ps
// Module: wt_sync
// Clock-domain crossings for the autonomous-clock path.
//  - The run request is passed into the aclk domain through STAGES flops. This
//    is the synchronous gate release.
//  - Each aclk timeout flips a toggle. The toggle is passed into the bus domain
//    through STAGES flops and then edge-detected into one flag-set pulse.
// Assumes rst_n is held low for at least a few aclk periods.
module wt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic aclk,
    input  logic rst_n,
    input  logic run_req,
    output logic run_a,
    input  logic tick_a,
    output logic set_pulse
);
    localparam int CHAIN = STAGES + 1;

    logic [STAGES-1:0] req_sync;
    logic              tog_a;
    logic [CHAIN-1:0]  tog_sync;

    // Gate-release synchronizer: shift the run request into the aclk domain.
    always_ff @(posedge aclk) begin
        if (!rst_n) begin
            req_sync <= '0;
        end else begin
            req_sync <= {req_sync[STAGES-2:0], run_req};
        end
    end

    assign run_a = req_sync[STAGES-1];

    // Timeout toggle in the aclk domain: one flip per period end.
    always_ff @(posedge aclk) begin
        if (!rst_n) begin
            tog_a <= 1'b0;
        end else if (tick_a) begin
            tog_a <= ~tog_a;
        end
    end

    // Toggle synchronizer and edge-detect history in the bus domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_sync <= '0;
        end else begin
            tog_sync <= {tog_sync[CHAIN-2:0], tog_a};
        end
    end

    assign set_pulse = tog_sync[CHAIN-1] ^ tog_sync[CHAIN-2];

    // R11: every crossed timeout is a single-cycle pulse
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> !set_pulse);
endmodule

// File: rtl/wt_regs.sv
`timescale 1ns/1ps
// Module: wt_regs
// The byte-wide register file: control, flag and the two rate bytes.
// The rate bytes and the source bit are writable only while run is 0. The flag
// is sticky and cleared by writing 1. A set request wins over a clear in the
// same cycle.
module wt_regs
    import wt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_flag,
    output logic [DATA_W-1:0] rd_data,
    output logic              run,
    output logic              src_bus,
    output logic              ien,
    output logic              flag,
    output logic [RATE_W-1:0] rate
);
    logic wr_ctrl, wr_stat, wr_rhi, wr_rlo, clr_req;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign wr_rhi  = wr_en && (addr == A_RHI);
    assign wr_rlo  = wr_en && (addr == A_RLO);
    assign clr_req = wr_stat && wr_data[B_FLAG];

    // Control process: run and interrupt enable always; source only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            src_bus <= 1'b0;
            ien     <= 1'b0;
        end else if (wr_ctrl) begin
            run <= wr_data[B_RUN];
            ien <= wr_data[B_IEN];
            if (!run) begin
                src_bus <= wr_data[B_SRC];
            end
        end
    end

    // Rate process: each byte is written only while the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate <= '0;
        end else if (!run) begin
            if (wr_rhi) begin
                rate[15:8] <= wr_data;
            end
            if (wr_rlo) begin
                rate[7:0] <= wr_data;
            end
        end
    end

    // Flag process: set by a timeout, cleared by writing 1, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_flag) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // Read mux process: present the addressed byte.
    always_comb begin
        rd_data = '0;
        case (addr)
            A_CTRL: begin
                rd_data[B_RUN] = run;
                rd_data[B_SRC] = src_bus;
                rd_data[B_IEN] = ien;
            end
            A_STAT: rd_data[B_FLAG] = flag;
            A_RHI:  rd_data = rate[15:8];
            default: rd_data = rate[7:0];
        endcase
    end

    // R3: a rate write during a run leaves the rate untouched
    a_r3_rate_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (wr_rhi || wr_rlo)) |=> $stable(rate));

    // R9: the source bit cannot change while the timer runs
    a_r9_src_locked: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(src_bus));

    // R7: a set flag survives any cycle without a clear request
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
endmodule

// File: rtl/wake_timer.sv
`timescale 1ns/1ps
// Module: wake_timer (top)
// Periodic wake-up interrupt timer. One period counter runs on the bus clock and
// a second runs on the autonomous clock. The source bit decides which one the
// run enable starts. Both counters feed the sticky flag: the bus counter
// directly, the autonomous counter through the toggle crossing.
// Assumes rst_n is synchronous to clk and is held long enough to cover aclk.
module wake_timer
    import wt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aclk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int SYNC_STAGES = 2;

    logic              run, src_bus, ien, flag;
    logic [RATE_W-1:0] rate;
    logic              run_bus, run_req_a, run_a;
    logic              tick_bus, tick_a, set_from_a, set_flag;

    assign run_bus   = run && src_bus;
    assign run_req_a = run && !src_bus;
    assign set_flag  = tick_bus || set_from_a;
    assign irq       = flag && ien;

    wt_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .set_flag (set_flag),
        .rd_data  (rd_data),
        .run      (run),
        .src_bus  (src_bus),
        .ien      (ien),
        .flag     (flag),
        .rate     (rate)
    );

    wt_period_counter #(.RATE_W(RATE_W)) u_cnt_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_bus),
        .rate  (rate),
        .tick  (tick_bus)
    );

    wt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .aclk      (aclk),
        .rst_n     (rst_n),
        .run_req   (run_req_a),
        .run_a     (run_a),
        .tick_a    (tick_a),
        .set_pulse (set_from_a)
    );

    wt_period_counter #(.RATE_W(RATE_W)) u_cnt_acl (
        .clk   (aclk),
        .rst_n (rst_n),
        .run   (run_a),
        .rate  (rate),
        .tick  (tick_a)
    );

    // R10: no timeout can reach the flag while the timer is stopped
    a_r10_no_bus_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick_bus);

    // R8: the interrupt line is never high without a set flag
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

// File: tb/test_wake_timer.sv
`timescale 1ns/1ps
// Bench: sweeps the rate in both clock modes and checks register behaviour.
module test_wake_timer;
    logic       clk = 1'b0;
    logic       aclk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;

    int     n_chk = 0;
    int     n_fail = 0;
    longint cyc = 0;

    localparam int ACLK_NS = 40;

    always #2 clk = ~clk;
    initial begin
        #1;
        forever #(ACLK_NS/2) aclk = ~aclk;
    end
    always @(posedge clk) cyc <= cyc + 1;

    wake_timer i_wake_timer (
        .clk(clk), .rst_n(rst_n), .aclk(aclk), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_bus(input int rate);
        longint p, c_en, c_prev;
        p = 2 * (rate + 1);
        wr(2'd0, 8'h00);
        wr(2'd2, rate[15:8]);
        wr(2'd3, rate[7:0]);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h07);
        c_en = cyc;
        c_prev = c_en;
        for (int k = 0; k < 3; k++) begin
            while (!irq) @(negedge clk);
            chk((cyc - c_prev) == p, "R4 bus period", cyc - c_prev, p);
            c_prev = cyc;
            wr(2'd1, 8'h01);
        end
    endtask

    task automatic run_acl(input int rate);
        longint p;
        time t_en, t_prev, t_now;
        p = 2 * (rate + 1);
        wr(2'd0, 8'h00);
        idle(40);
        wr(2'd2, rate[15:8]);
        wr(2'd3, rate[7:0]);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h05);
        t_en = $time - 2;
        while (!irq) @(negedge clk);
        t_now = $time;
        chk((t_now - t_en) >= (p + 1) * ACLK_NS && (t_now - t_en) <= (p + 3) * ACLK_NS + 20,
            "R6 first autonomous period", longint'(t_now - t_en), (p + 1) * ACLK_NS);
        t_prev = t_now;
        wr(2'd1, 8'h01);
        for (int k = 0; k < 2; k++) begin
            while (!irq) @(negedge clk);
            t_now = $time;
            chk((t_now - t_prev) == p * ACLK_NS, "R5 R11 autonomous period",
                longint'(t_now - t_prev), p * ACLK_NS);
            t_prev = t_now;
            wr(2'd1, 8'h01);
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        longint c_en;
        idle(20);
        rst_n = 1'b1;
        idle(2);

        // R1: every register and irq are zero after reset
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk(d == 8'h00, "R1 reset value", d, 0);
        end
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);

        // R2: rate bytes read back as written while stopped
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h3C);
        rd(2'd2, d); chk(d == 8'hA5, "R2 high byte", d, 8'hA5);
        rd(2'd3, d); chk(d == 8'h3C, "R2 low byte", d, 8'h3C);

        // R3 and R9: locked while running
        wr(2'd0, 8'h03);
        wr(2'd2, 8'h11);
        wr(2'd3, 8'h22);
        wr(2'd0, 8'h01);
        rd(2'd2, d); chk(d == 8'hA5, "R3 high byte locked", d, 8'hA5);
        rd(2'd3, d); chk(d == 8'h3C, "R3 low byte locked", d, 8'h3C);
        rd(2'd0, d); chk(d[1] == 1'b1, "R9 source locked", d[1], 1);
        wr(2'd0, 8'h00);

        // R4: bus-clock sweep over small rates and one high-byte rate
        for (int r = 0; r < 16; r++) run_bus(r);
        run_bus(16'h0100);

        // R8 and R7: masking and write-one-to-clear
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h01);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h03);
        idle(10);
        rd(2'd1, d);
        chk(d[0] == 1'b1, "R8 flag set while masked", d[0], 1);
        chk(irq == 1'b0, "R8 irq masked", irq, 0);
        wr(2'd0, 8'h07);
        chk(irq == 1'b1, "R8 irq unmasked", irq, 1);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk(d[0] == 1'b1, "R7 write 0 keeps flag", d[0], 1);
        wr(2'd1, 8'h01);
        rd(2'd1, d); chk(d[0] == 1'b0, "R7 write 1 clears flag", d[0], 0);

        // R10: stopped timer sets no flag, re-enable gives a full period
        wr(2'd3, 8'h09);
        wr(2'd0, 8'h03);
        idle(10);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h01);
        idle(50);
        rd(2'd1, d); chk(d[0] == 1'b0, "R10 no flag while stopped", d[0], 0);
        wr(2'd0, 8'h07);
        c_en = cyc;
        while (!irq) @(negedge clk);
        chk((cyc - c_en) == 20, "R10 full period after re-enable", cyc - c_en, 20);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h01);

        // R5, R6, R11: autonomous-clock sweep
        for (int r = 0; r < 5; r++) run_acl(r);
        wr(2'd0, 8'h00);
        idle(40);
        wr(2'd1, 8'h01);
        idle(200);
        rd(2'd1, d); chk(d[0] == 1'b0, "R10 autonomous stopped", d[0], 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule